// File: doc/BRIEF.md
# Two-Level Address Translation Lookup Sequencer

This block resolves one memory access at a time into a physical address. It first searches a small micro TLB chosen by the access kind, with separate instruction and data micro TLBs. If that misses, it searches a larger shared main TLB. If both miss, it issues a translation table walk request. A walk is either blocked by a per-table-base disable bit or routed to a data-cache port or an external-memory port, depending on a walk cacheability code.

When a walk returns, its entry is written into the main TLB. In the next cycle it is written into the micro TLB for the access kind, and the access is then retried from the micro TLB. A main TLB hit also refills the micro TLB and retries. Every final answer comes from a micro TLB hit, a disabled walk or a failed walk.

On a micro TLB hit the entry's domain and access permission are checked against the request's privilege and direction. A passing access returns the physical address together with security, shareability and memory type, where the last two are looked up in an external remap table. Requests use a valid/ready handshake. Answers come as a one-cycle done pulse carrying either a translated address or a fault code. A flush input removes all non-global entries of one address space identifier from every level.

Top module: `tlb_walk_seq`

## Requirements
- R1: The first lookup goes to the micro TLB of the access kind (`req_instr`=1 instruction, 0 data). The two micro TLBs are separate: a hit answers with `rsp_done` one cycle after the lookup cycle, which is two rising edges after acceptance. An entry refilled for one kind is not hit by the other kind.
- R2: The main TLB is searched only after a micro TLB miss. A main TLB hit refills the micro TLB of that kind in the next cycle and the access is retried, so `rsp_done` comes five edges after acceptance and no walk is requested.
- R3: An entry hits only when its 20-bit page number equals `req_va[31:12]`, its security bit equals `req_ns`, and either it is global or its identifier equals `req_asid`.
- R4: A walk is requested only after both levels miss. If the disable bit of the selected base (`cfg_walk_off0` or `cfg_walk_off1`) is set, no walk is issued and the response carries fault code 1 (translation) three edges after acceptance.
- R5: While a walk is pending, `walk_dc_valid` is raised when `cfg_walk_cache[0]`=1 (codes 01 and 11, write-back), and otherwise `walk_mem_valid` is raised (codes 00 and 10). The two are never high together.
- R6: Base 1 is selected when any of the top `cfg_split` bits of the virtual address is set. Otherwise, and always when `cfg_split`=0, base 0 is selected. The choice is shown on `walk_base`.
- R7: The domain field picks a two-bit mode from `cfg_dacr` at bit 2*domain. Mode 00 or 10 gives fault code 2 (domain). Mode 11 allows any access. Mode 01 applies the permission check.
- R8: Under mode 01, the two permission bits act as follows. Code 00 denies every access. Code 01 allows privileged accesses only. Code 10 denies writes from unprivileged accesses. Code 11 allows all. A denial gives fault code 3, and any nonzero fault is reported with `rsp_pa` equal to zero.
- R9: On a passing access, `rsp_pa` is the entry's page number followed by `req_va[11:0]`, and `rsp_secure` is the inverse of the entry's security bit. `rsp_share` and `rsp_mtype` are bits 2 and 1:0 of the 3-bit remap slot at position 3*attr of `cfg_remap`.
- R10: When a walk completes without fault, the result fills the main TLB on that edge and the micro TLB on the next. The retried access then answers, giving `rsp_done` six edges after acceptance. A repeat of the same access hits the micro TLB.
- R11: A walk that ends with `walk_fault` gives fault code 4 four edges after acceptance and fills no TLB level.
- R12: A `flush_valid` cycle invalidates, at every level, the valid non-global entries whose identifier equals `flush_asid`. Global entries and entries of other identifiers are kept.
- R13: Each level replaces entries round-robin. After as many new fills as a level has entries, the oldest fill of that level is gone.
- R14: `req_ready` is high only while no access is in progress, and `rsp_done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_instr | input | 1 | 1 instruction fetch, 0 data access |
| req_asid | input | 8 | Current address space identifier |
| req_ns | input | 1 | Current security state, 1 non-secure |
| req_priv | input | 1 | Privileged access |
| req_write | input | 1 | Write access |
| flush_valid | input | 1 | Flush by identifier |
| flush_asid | input | 8 | Identifier to flush |
| cfg_split | input | 3 | Number of top address bits selecting base 1 |
| cfg_walk_off0 | input | 1 | Walks through base 0 disabled |
| cfg_walk_off1 | input | 1 | Walks through base 1 disabled |
| cfg_walk_cache | input | 2 | Walk cacheability code |
| cfg_dacr | input | 32 | Sixteen two-bit domain modes |
| cfg_remap | input | 24 | Eight three-bit remap slots |
| walk_dc_valid | output | 1 | Walk request to the data-cache port |
| walk_mem_valid | output | 1 | Walk request to the external-memory port |
| walk_va | output | 32 | Address to be walked |
| walk_base | output | 1 | Selected table base |
| walk_done | input | 1 | Walk result valid |
| walk_fault | input | 1 | Walk found no valid mapping |
| walk_ppn | input | 20 | Walked physical page number |
| walk_global | input | 1 | Walked entry is global |
| walk_ap | input | 2 | Walked permission bits |
| walk_dom | input | 4 | Walked domain |
| walk_attr | input | 3 | Walked remap slot index |
| rsp_done | output | 1 | One-cycle response pulse |
| rsp_fault | output | 3 | 0 none, 1 translation, 2 domain, 3 permission, 4 walk |
| rsp_pa | output | 32 | Physical address, zero on fault |
| rsp_secure | output | 1 | Secure access |
| rsp_share | output | 1 | Shareable |
| rsp_mtype | output | 2 | Memory type from remap |

## Verification
The bench builds the block with four micro TLB entries and eight main TLB entries instead of eight and thirty-two. With these sizes, a handful of walks evicts an entry from the micro level while it stays in the main level, and a dozen walks evicts it from both. This brings both round-robin rollovers and the main-hit refill path into a short run. All other checks follow from response latency, which tells a micro hit, a main hit, a disabled walk, a failed walk and a completed walk apart at the ports.

// File: rtl/tlbseq_pkg.sv
package tlbseq_pkg;
    parameter int VA_W      = 32;
    parameter int PAGE_BITS = 12;
    parameter int VPN_W     = VA_W - PAGE_BITS;
    parameter int ASID_W    = 8;
    parameter int DOM_W     = 4;
    parameter int ATTR_W    = 3;
    parameter int FLT_W     = 3;
    parameter int DACR_W    = 2 * (1 << DOM_W);
    parameter int SLOT_W    = 3;
    parameter int REMAP_W   = SLOT_W * (1 << ATTR_W);

    localparam logic [FLT_W-1:0] FLT_NONE   = 3'd0;
    localparam logic [FLT_W-1:0] FLT_XLATE  = 3'd1;
    localparam logic [FLT_W-1:0] FLT_DOMAIN = 3'd2;
    localparam logic [FLT_W-1:0] FLT_PERM   = 3'd3;
    localparam logic [FLT_W-1:0] FLT_WALK   = 3'd4;

    typedef struct packed {
        logic              vld;
        logic [VPN_W-1:0]  vpn;
        logic [VPN_W-1:0]  ppn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic              ns;
        logic [1:0]        ap;
        logic [DOM_W-1:0]  dom;
        logic [ATTR_W-1:0] attr;
    } tlb_ent_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UTLB,
        ST_MTLB,
        ST_WALK,
        ST_FILL
    } seq_st_t;
endpackage

// File: rtl/tlb_assoc.sv
module tlb_assoc
    import tlbseq_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_ns,
    output logic              lk_hit,
    output tlb_ent_t          lk_ent,
    input  logic              wr_en,
    input  tlb_ent_t          wr_ent,
    input  logic              fl_en,
    input  logic [ASID_W-1:0] fl_asid
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        tlb_ent_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]       ptr;
    } arr_st_t;

    arr_st_t s_d, s_q;
    logic [ENTRIES-1:0] match;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = s_q.ent[g].vld
                           && (s_q.ent[g].vpn == lk_vpn)
                           && (s_q.ent[g].ns == lk_ns)
                           && (s_q.ent[g].glob || (s_q.ent[g].asid == lk_asid));
        end
    endgenerate

    always_comb begin
        lk_hit = |match;
        lk_ent = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) lk_ent = s_q.ent[i];
        end
    end

    always_comb begin
        s_d = s_q;
        if (fl_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (s_q.ent[i].vld && !s_q.ent[i].glob && (s_q.ent[i].asid == fl_asid))
                    s_d.ent[i].vld = 1'b0;
            end
        end
        if (wr_en) begin
            s_d.ent[s_q.ptr]     = wr_ent;
            s_d.ent[s_q.ptr].vld = 1'b1;
            s_d.ptr              = (s_q.ptr == LAST) ? '0 : s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_fill_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fl_en) |=> s_q.ent[$past(s_q.ptr)].vld);

    assert_flush_keeps_global_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_en && !wr_en && lk_hit && lk_ent.glob) |=> lk_hit || !$stable(lk_vpn)
            || !$stable(lk_ns));
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
    import tlbseq_pkg::*;
(
    input  logic [1:0]        ap,
    input  logic [DOM_W-1:0]  dom,
    input  logic [DACR_W-1:0] dacr,
    input  logic              priv,
    input  logic              wr,
    output logic [FLT_W-1:0]  fault
);
    logic [1:0] dmode;

    always_comb begin
        dmode = dacr[int'(dom) * 2 +: 2];
        fault = FLT_NONE;
        unique case (dmode)
            2'b11: fault = FLT_NONE;
            2'b01: begin
                unique case (ap)
                    2'b00: fault = FLT_PERM;
                    2'b01: fault = priv ? FLT_NONE : FLT_PERM;
                    2'b10: fault = (!priv && wr) ? FLT_PERM : FLT_NONE;
                    default: fault = FLT_NONE;
                endcase
            end
            default: fault = FLT_DOMAIN;
        endcase
    end
endmodule

// File: rtl/tlb_attr_map.sv
module tlb_attr_map
    import tlbseq_pkg::*;
(
    input  logic [ATTR_W-1:0]  idx,
    input  logic               ns,
    input  logic [REMAP_W-1:0] remap,
    output logic               secure,
    output logic               share,
    output logic [1:0]         mtype
);
    logic [SLOT_W-1:0] slot;

    always_comb begin
        slot   = remap[int'(idx) * SLOT_W +: SLOT_W];
        share  = slot[2];
        mtype  = slot[1:0];
        secure = !ns;
    end
endmodule

// File: rtl/tlb_walk_seq.sv
module tlb_walk_seq
    import tlbseq_pkg::*;
#(
    parameter int UTLB_N  = 8,
    parameter int MTLB_N  = 32,
    parameter int SPLIT_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_va,
    input  logic               req_instr,
    input  logic [ASID_W-1:0]  req_asid,
    input  logic               req_ns,
    input  logic               req_priv,
    input  logic               req_write,
    input  logic               flush_valid,
    input  logic [ASID_W-1:0]  flush_asid,
    input  logic [SPLIT_W-1:0] cfg_split,
    input  logic               cfg_walk_off0,
    input  logic               cfg_walk_off1,
    input  logic [1:0]         cfg_walk_cache,
    input  logic [DACR_W-1:0]  cfg_dacr,
    input  logic [REMAP_W-1:0] cfg_remap,
    output logic               walk_dc_valid,
    output logic               walk_mem_valid,
    output logic [VA_W-1:0]    walk_va,
    output logic               walk_base,
    input  logic               walk_done,
    input  logic               walk_fault,
    input  logic [VPN_W-1:0]   walk_ppn,
    input  logic               walk_global,
    input  logic [1:0]         walk_ap,
    input  logic [DOM_W-1:0]   walk_dom,
    input  logic [ATTR_W-1:0]  walk_attr,
    output logic               rsp_done,
    output logic [FLT_W-1:0]   rsp_fault,
    output logic [VA_W-1:0]    rsp_pa,
    output logic               rsp_secure,
    output logic               rsp_share,
    output logic [1:0]         rsp_mtype
);
    typedef struct packed {
        seq_st_t           st;
        logic [VA_W-1:0]   va;
        logic              instr;
        logic [ASID_W-1:0] asid;
        logic              ns;
        logic              priv;
        logic              wr;
        tlb_ent_t          ent;
        logic              done;
        logic [FLT_W-1:0]  flt;
        logic [VA_W-1:0]   pa;
        logic              sec;
        logic              shr;
        logic [1:0]        mt;
    } ctl_t;

    ctl_t d, q;

    logic [VPN_W-1:0] cur_vpn;
    logic             iu_hit, du_hit, m_hit, u_hit;
    tlb_ent_t         iu_ent, du_ent, m_ent, u_ent, walk_ent;
    logic             iu_wr, du_wr, m_wr;
    logic [FLT_W-1:0] pc_flt;
    logic             am_sec, am_shr;
    logic [1:0]       am_mt;
    logic [VA_W-1:0]  hi_mask;
    logic             base_sel, base_off, walk_any;

    assign cur_vpn = q.va[VA_W-1:PAGE_BITS];

    tlb_assoc #(.ENTRIES(UTLB_N)) u_itlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(cur_vpn), .lk_asid(q.asid), .lk_ns(q.ns),
        .lk_hit(iu_hit), .lk_ent(iu_ent),
        .wr_en(iu_wr), .wr_ent(q.ent),
        .fl_en(flush_valid), .fl_asid(flush_asid)
    );

    tlb_assoc #(.ENTRIES(UTLB_N)) u_dtlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(cur_vpn), .lk_asid(q.asid), .lk_ns(q.ns),
        .lk_hit(du_hit), .lk_ent(du_ent),
        .wr_en(du_wr), .wr_ent(q.ent),
        .fl_en(flush_valid), .fl_asid(flush_asid)
    );

    tlb_assoc #(.ENTRIES(MTLB_N)) u_mtlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(cur_vpn), .lk_asid(q.asid), .lk_ns(q.ns),
        .lk_hit(m_hit), .lk_ent(m_ent),
        .wr_en(m_wr), .wr_ent(walk_ent),
        .fl_en(flush_valid), .fl_asid(flush_asid)
    );

    assign u_hit = q.instr ? iu_hit : du_hit;
    assign u_ent = q.instr ? iu_ent : du_ent;

    tlb_perm_check u_perm (
        .ap(u_ent.ap), .dom(u_ent.dom), .dacr(cfg_dacr),
        .priv(q.priv), .wr(q.wr), .fault(pc_flt)
    );

    tlb_attr_map u_attr (
        .idx(u_ent.attr), .ns(u_ent.ns), .remap(cfg_remap),
        .secure(am_sec), .share(am_shr), .mtype(am_mt)
    );

    always_comb begin
        hi_mask  = ~({VA_W{1'b1}} >> cfg_split);
        base_sel = |(q.va & hi_mask);
        base_off = base_sel ? cfg_walk_off1 : cfg_walk_off0;
    end

    always_comb begin
        walk_ent      = '0;
        walk_ent.vld  = 1'b1;
        walk_ent.vpn  = cur_vpn;
        walk_ent.ppn  = walk_ppn;
        walk_ent.asid = q.asid;
        walk_ent.glob = walk_global;
        walk_ent.ns   = q.ns;
        walk_ent.ap   = walk_ap;
        walk_ent.dom  = walk_dom;
        walk_ent.attr = walk_attr;
    end

    always_comb begin
        walk_any       = (q.st == ST_WALK);
        walk_dc_valid  = walk_any && cfg_walk_cache[0];
        walk_mem_valid = walk_any && !cfg_walk_cache[0];
        walk_va        = q.va;
        walk_base      = base_sel;
        m_wr           = walk_any && walk_done && !walk_fault;
        iu_wr          = (q.st == ST_FILL) && q.instr;
        du_wr          = (q.st == ST_FILL) && !q.instr;
        req_ready      = (q.st == ST_IDLE);
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_UTLB;
                    d.va    = req_va;
                    d.instr = req_instr;
                    d.asid  = req_asid;
                    d.ns    = req_ns;
                    d.priv  = req_priv;
                    d.wr    = req_write;
                end
            end
            ST_UTLB: begin
                if (u_hit) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.flt  = pc_flt;
                    if (pc_flt == FLT_NONE) begin
                        d.pa  = {u_ent.ppn, q.va[PAGE_BITS-1:0]};
                        d.sec = am_sec;
                        d.shr = am_shr;
                        d.mt  = am_mt;
                    end else begin
                        d.pa  = '0;
                        d.sec = 1'b0;
                        d.shr = 1'b0;
                        d.mt  = '0;
                    end
                end else begin
                    d.st = ST_MTLB;
                end
            end
            ST_MTLB: begin
                if (m_hit) begin
                    d.ent = m_ent;
                    d.st  = ST_FILL;
                end else if (base_off) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.flt  = FLT_XLATE;
                    d.pa   = '0;
                    d.sec  = 1'b0;
                    d.shr  = 1'b0;
                    d.mt   = '0;
                end else begin
                    d.st = ST_WALK;
                end
            end
            ST_WALK: begin
                if (walk_done) begin
                    if (walk_fault) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                        d.flt  = FLT_WALK;
                        d.pa   = '0;
                        d.sec  = 1'b0;
                        d.shr  = 1'b0;
                        d.mt   = '0;
                    end else begin
                        d.ent = walk_ent;
                        d.st  = ST_FILL;
                    end
                end
            end
            ST_FILL: d.st = ST_UTLB;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rsp_done   = q.done;
    assign rsp_fault  = q.flt;
    assign rsp_pa     = q.pa;
    assign rsp_secure = q.sec;
    assign rsp_share  = q.shr;
    assign rsp_mtype  = q.mt;

    assert_micro_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_MTLB) |-> ($past(q.st) == ST_UTLB) && !$past(u_hit));

    assert_refill_hits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_UTLB) && ($past(q.st) == ST_FILL) && !$past(flush_valid)) |-> u_hit);

    assert_walk_after_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(walk_any) |-> ($past(q.st) == ST_MTLB) && !$past(m_hit));

    assert_walk_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (walk_dc_valid || walk_mem_valid) |-> !(walk_base ? cfg_walk_off1 : cfg_walk_off0));

    assert_route_dc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        walk_dc_valid |-> cfg_walk_cache[0]);

    assert_route_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({walk_dc_valid, walk_mem_valid}));

    assert_abort_no_pa_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && (rsp_fault != FLT_NONE)) |-> (rsp_pa == '0));

    assert_done_pulse_R14: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_busy_after_accept_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/sim_tlb_walk_seq.sv
module sim_tlb_walk_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_instr = 1'b0;
    logic [7:0]  req_asid = '0;
    logic        req_ns = 1'b0;
    logic        req_priv = 1'b0;
    logic        req_write = 1'b0;
    logic        flush_valid = 1'b0;
    logic [7:0]  flush_asid = '0;
    logic [2:0]  cfg_split = 3'd1;
    logic        cfg_walk_off0 = 1'b0;
    logic        cfg_walk_off1 = 1'b0;
    logic [1:0]  cfg_walk_cache = 2'b01;
    logic [31:0] cfg_dacr = 32'h0000_000D;
    logic [23:0] cfg_remap;
    logic        walk_dc_valid, walk_mem_valid, walk_base;
    logic [31:0] walk_va;
    logic        walk_done = 1'b0;
    logic        walk_fault = 1'b0;
    logic [19:0] walk_ppn = '0;
    logic        walk_global = 1'b0;
    logic [1:0]  walk_ap = '0;
    logic [3:0]  walk_dom = '0;
    logic [2:0]  walk_attr = '0;
    logic        rsp_done, rsp_secure, rsp_share;
    logic [2:0]  rsp_fault;
    logic [31:0] rsp_pa;
    logic [1:0]  rsp_mtype;

    int n_chk = 0;
    int n_bad = 0;

    logic       w_glob = 1'b0;
    logic [1:0] w_ap = 2'd3;
    logic [3:0] w_dom = '0;
    logic [2:0] w_attr = '0;
    logic       w_fault = 1'b0;

    int         r_lat;
    logic       r_walk, r_dc, r_base;
    logic [2:0] r_flt;
    logic [31:0] r_pa;
    logic       r_sec, r_shr;
    logic [1:0] r_mt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_walk_seq #(.UTLB_N(4), .MTLB_N(8), .SPLIT_W(3)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_instr(req_instr), .req_asid(req_asid), .req_ns(req_ns),
        .req_priv(req_priv), .req_write(req_write),
        .flush_valid(flush_valid), .flush_asid(flush_asid),
        .cfg_split(cfg_split), .cfg_walk_off0(cfg_walk_off0), .cfg_walk_off1(cfg_walk_off1),
        .cfg_walk_cache(cfg_walk_cache), .cfg_dacr(cfg_dacr), .cfg_remap(cfg_remap),
        .walk_dc_valid(walk_dc_valid), .walk_mem_valid(walk_mem_valid),
        .walk_va(walk_va), .walk_base(walk_base),
        .walk_done(walk_done), .walk_fault(walk_fault), .walk_ppn(walk_ppn),
        .walk_global(walk_global), .walk_ap(walk_ap), .walk_dom(walk_dom),
        .walk_attr(walk_attr),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
        .rsp_secure(rsp_secure), .rsp_share(rsp_share), .rsp_mtype(rsp_mtype)
    );

    typedef struct packed {
        logic [31:0] va;
        logic        instr;
        logic [7:0]  asid;
        logic        ns;
        logic        priv;
        logic        wr;
        logic        glob;
        logic [1:0]  ap;
        logic [3:0]  dom;
        logic [2:0]  attr;
        logic [3:0]  lat;
        logic [2:0]  flt;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0001_2345, 1'b0, 8'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 4'd0, 3'd2, 4'd5, 3'd0},
        '{32'h0001_2345, 1'b0, 8'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 4'd0, 3'd2, 4'd1, 3'd0},
        '{32'h0001_2345, 1'b1, 8'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 4'd0, 3'd2, 4'd4, 3'd0},
        '{32'h0001_2345, 1'b1, 8'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 4'd0, 3'd2, 4'd1, 3'd0},
        '{32'h0001_2345, 1'b0, 8'd4, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 4'd0, 3'd2, 4'd5, 3'd0},
        '{32'h0001_2345, 1'b0, 8'd3, 1'b1, 1'b1, 1'b0, 1'b0, 2'd3, 4'd0, 3'd2, 4'd5, 3'd0},
        '{32'h8000_5000, 1'b0, 8'd3, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 4'd1, 3'd5, 4'd5, 3'd0},
        '{32'h8000_5000, 1'b0, 8'd9, 1'b0, 1'b1, 1'b0, 1'b1, 2'd3, 4'd1, 3'd5, 4'd1, 3'd0},
        '{32'h0040_0000, 1'b0, 8'd3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 4'd0, 3'd1, 4'd5, 3'd3},
        '{32'h0040_1000, 1'b0, 8'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 4'd2, 3'd1, 4'd5, 3'd2},
        '{32'h0040_2000, 1'b0, 8'd3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 4'd1, 3'd3, 4'd5, 3'd0},
        '{32'h0040_3000, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 4'd0, 3'd6, 4'd5, 3'd0},
        '{32'h0040_4000, 1'b0, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 4'd0, 3'd0, 4'd5, 3'd3},
        '{32'h0040_5000, 1'b0, 8'd3, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 4'd0, 3'd4, 4'd5, 3'd3}
    };

    function automatic logic [19:0] model_ppn(input logic [19:0] vpn);
        return vpn ^ 20'hABCDE;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [31:0] va, input logic instr, input logic [7:0] asid,
                          input logic ns, input logic priv, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_instr = instr; req_asid = asid;
        req_ns = ns; req_priv = priv; req_write = wr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R14 ready low while busy", {31'd0, req_ready}, 32'd0);
        r_lat = 0; r_walk = 1'b0; r_dc = 1'b0; r_base = 1'b0;
        while (r_lat < 40) begin
            @(negedge clk);
            r_lat++;
            walk_done = 1'b0;
            if (rsp_done) break;
            if ((walk_dc_valid || walk_mem_valid) && !r_walk) begin
                r_walk = 1'b1; r_dc = walk_dc_valid; r_base = walk_base;
                walk_done = 1'b1; walk_fault = w_fault;
                walk_ppn = model_ppn(walk_va[31:12]);
                walk_global = w_glob; walk_ap = w_ap; walk_dom = w_dom; walk_attr = w_attr;
            end
        end
        r_flt = rsp_fault; r_pa = rsp_pa; r_sec = rsp_secure; r_shr = rsp_share; r_mt = rsp_mtype;
        chk("R14 done seen", {31'd0, rsp_done}, 32'd1);
        @(negedge clk);
        chk("R14 done single cycle", {31'd0, rsp_done}, 32'd0);
    endtask

    task automatic walk_new(input logic [31:0] va, input logic [7:0] asid, input logic glob);
        w_glob = glob; w_ap = 2'd3; w_dom = 4'd0; w_attr = 3'd2; w_fault = 1'b0;
        do_req(va, 1'b0, asid, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic flush(input logic [7:0] asid);
        @(negedge clk);
        flush_valid = 1'b1; flush_asid = asid;
        @(negedge clk);
        flush_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) cfg_remap[i*3 +: 3] = 3'(i);
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R14 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R14 reset done low", {31'd0, rsp_done}, 32'd0);
        chk("R5 reset no walk", {30'd0, walk_dc_valid, walk_mem_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R14 ready after reset", {31'd0, req_ready}, 32'd1);

        // Table: R1 R2 R3 R7 R8 R9 R10
        for (int v = 0; v < NV; v++) begin
            w_glob = VECS[v].glob; w_ap = VECS[v].ap; w_dom = VECS[v].dom;
            w_attr = VECS[v].attr; w_fault = 1'b0;
            do_req(VECS[v].va, VECS[v].instr, VECS[v].asid, VECS[v].ns,
                   VECS[v].priv, VECS[v].wr);
            chk($sformatf("R1 R2 R3 R10 latency v%0d", v), r_lat, 32'(VECS[v].lat));
            chk($sformatf("R7 R8 fault v%0d", v), {29'd0, r_flt}, {29'd0, VECS[v].flt});
            chk($sformatf("R8 R9 pa v%0d", v), r_pa, (VECS[v].flt == 3'd0) ?
                {model_ppn(VECS[v].va[31:12]), VECS[v].va[11:0]} : 32'd0);
            if (VECS[v].flt == 3'd0)
                chk($sformatf("R9 attrs v%0d", v), {28'd0, r_sec, r_shr, r_mt},
                    {28'd0, !VECS[v].ns, VECS[v].attr});
            chk($sformatf("R4 walk issued v%0d", v), {31'd0, r_walk},
                {31'd0, VECS[v].lat == 4'd5});
            if (r_walk)
                chk($sformatf("R5 R6 route v%0d", v), {30'd0, r_dc, r_base},
                    {30'd0, 1'b1, VECS[v].va[31]});
        end

        // R4: disabled walk through base 0
        cfg_walk_off0 = 1'b1;
        walk_new(32'h0050_0000, 8'd3, 1'b0);
        chk("R4 disabled fault", {29'd0, r_flt}, 32'd1);
        chk("R4 disabled latency", r_lat, 32'd2);
        chk("R4 disabled no walk", {31'd0, r_walk}, 32'd0);
        chk("R4 disabled pa", r_pa, 32'd0);
        // R6: base 1 still walks
        walk_new(32'h9000_0000, 8'd3, 1'b0);
        chk("R6 base1 walk", {30'd0, r_walk, r_base}, 32'd3);
        chk("R6 base1 fault", {29'd0, r_flt}, 32'd0);
        cfg_split = 3'd2;
        walk_new(32'h4000_1000, 8'd3, 1'b0);
        chk("R6 split2 selects base1", {30'd0, r_walk, r_base}, 32'd3);
        cfg_split = 3'd1;
        walk_new(32'h4000_2000, 8'd3, 1'b0);
        chk("R6 split1 selects base0", {29'd0, r_flt}, 32'd1);
        cfg_split = 3'd0;
        walk_new(32'hF000_3000, 8'd3, 1'b0);
        chk("R6 split0 always base0", {29'd0, r_flt}, 32'd1);
        cfg_split = 3'd1;
        cfg_walk_off0 = 1'b0;

        // R5: routing by cacheability code
        cfg_walk_cache = 2'b10;
        walk_new(32'h0060_0000, 8'd3, 1'b0);
        chk("R5 write-through to memory", {30'd0, r_walk, r_dc}, 32'd2);
        cfg_walk_cache = 2'b00;
        walk_new(32'h0060_1000, 8'd3, 1'b0);
        chk("R5 non-cacheable to memory", {30'd0, r_walk, r_dc}, 32'd2);
        cfg_walk_cache = 2'b11;
        walk_new(32'h0060_2000, 8'd3, 1'b0);
        chk("R5 write-back to cache", {30'd0, r_walk, r_dc}, 32'd3);
        cfg_walk_cache = 2'b01;

        // R11: failed walk fills nothing
        w_fault = 1'b1;
        do_req(32'h0070_0000, 1'b0, 8'd3, 1'b0, 1'b1, 1'b0);
        chk("R11 walk fault code", {29'd0, r_flt}, 32'd4);
        chk("R11 walk fault latency", r_lat, 32'd3);
        chk("R11 walk fault pa", r_pa, 32'd0);
        walk_new(32'h0070_0000, 8'd3, 1'b0);
        chk("R11 no fill after fault", r_lat, 32'd5);

        // R12: flush by identifier
        walk_new(32'h00A0_0000, 8'd3, 1'b1);
        walk_new(32'h00A0_1000, 8'd3, 1'b0);
        walk_new(32'h00A0_2000, 8'd3, 1'b0);
        flush(8'd5);
        walk_new(32'h00A0_2000, 8'd3, 1'b0);
        chk("R12 other identifier kept", r_lat, 32'd1);
        flush(8'd3);
        walk_new(32'h00A0_0000, 8'd3, 1'b1);
        chk("R12 global kept", r_lat, 32'd1);
        walk_new(32'h00A0_1000, 8'd3, 1'b0);
        chk("R12 non-global removed from both levels", r_lat, 32'd5);

        // R13: round-robin eviction, micro 4 and main 8 entries
        for (int k = 0; k < 5; k++) walk_new(32'h0100_0000 + 32'(k) * 32'h1000, 8'd7, 1'b0);
        walk_new(32'h0100_0000, 8'd7, 1'b0);
        chk("R13 micro evicted main kept", r_lat, 32'd4);
        for (int k = 5; k < 13; k++) walk_new(32'h0100_0000 + 32'(k) * 32'h1000, 8'd7, 1'b0);
        walk_new(32'h0100_0000, 8'd7, 1'b0);
        chk("R13 main evicted", r_lat, 32'd5);
        walk_new(32'h0100_0000, 8'd7, 1'b0);
        chk("R10 repeat hits micro", r_lat, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule